// File: doc/BRIEF.md
# Byte-Addressed I2C Target with Auto-Incrementing Location Pointer

This block is an I2C target that gives a bus controller access to a 128-byte register memory. It runs on a fast system clock. The SCL and SDA lines are brought into that clock through synchronizer stages and watched for edges and bus conditions. It recognises START, repeated START and STOP. It compares the 7-bit address that follows a START against its own address, which is a parameter, and it pulls SDA low during the ninth clock to acknowledge.

In a write transfer, the first data byte after the address sets the location pointer. Each later byte is stored at the pointer, and the pointer then moves to the next location. A read transfer returns bytes from the pointer onward, MSB first. The read continues for as long as the controller acknowledges each byte. A read from a chosen location takes one combined transfer: a write that carries only the pointer byte, then a repeated START, then the read address. A STOP that arrives anywhere, even in the middle of a byte, ends the transfer and discards any partial byte.

The SDA output is an open-drain enable: when it is 1, the pad pulls SDA low. The block does not stretch the clock. It has no 10-bit or general-call addressing.

Top module: `i2c_ptr_target`

## Requirements
- R1: While reset is high and after its release, the SDA pull-down enable is 0 and every memory byte reads as 0x00.
- R2: When the 8 bits after a START or repeated START are the own address (default 7'h52) followed by a direction bit, the target pulls SDA low during the ninth SCL clock. The direction bit is the last bit: 0 means write, 1 means read.
- R3: If the address does not match, the target never pulls SDA low, and the bytes that follow change no memory location, until the next START or STOP.
- R4: In a write transfer, the first byte after the address is acknowledged and loads the pointer from its lower 7 bits. Bit 7 of that byte is ignored.
- R5: Each later byte in the same write transfer is acknowledged and stored at the pointer, and the pointer then increments.
- R6: A repeated START followed by the read address starts a read at the current pointer, with no STOP in between. Data is sent MSB first.
- R7: After each read byte the pointer increments. A low SDA level from the controller on the ninth clock makes the target send the next byte. A high level makes it stop driving until the next START or STOP.
- R8: A STOP at any point, including partway through a byte, returns the target to idle with SDA released. The partial byte is not stored.
- R9: The pointer wraps from 127 to 0, for both reads and writes.
- R10: The SDA pull-down enable changes only while the synchronized SCL is low. An acknowledge is released at the SCL falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL level as seen on the pad |
| sda_in | input | 1 | SDA level as seen on the pad (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Some checks hold on every cycle, and assertions cover them:
- The pull-down enable changes only while synchronized SCL is low.
- A detected STOP always brings the target to idle with SDA released.
- The target never drives while it is ignoring traffic, and always drives during its acknowledge clock.
- The pointer wraps from 127 to 0.
- Every memory write lands at the addressed location.

Other properties need whole bus transactions, which only the bench scenarios show:
- The first byte of a write is used as a pointer and later bytes as data.
- A combined write-then-read returns the stored bytes from the pointer onward.
- A NACK ends a read, and a repeated START after it starts a new read.
- A foreign address leaves the memory untouched.
- A STOP in the middle of a byte leaves no trace.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CNT_W   = 4;
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_t;

    typedef struct packed {
        logic scl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] rx, input logic [6:0] own);
        return rx[BYTE_W-1:1] == own;
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_ptr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_in;
                    sda_sh <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_in};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_sh[STAGES-1];
            sda_d <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        evt.scl      = scl_sh[STAGES-1];
        evt.sda      = sda_sh[STAGES-1];
        evt.scl_rise = evt.scl & ~scl_d;
        evt.scl_fall = ~evt.scl & scl_d;
        evt.start    = evt.scl & scl_d & sda_d & ~evt.sda;
        evt.stop     = evt.scl & scl_d & ~sda_d & evt.sda;
    end
endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> cells[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0]  OWN_ADDR    = 7'h52,
    parameter int unsigned MEM_DEPTH   = 128,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PW = $clog2(MEM_DEPTH)
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull
);
    bus_evt_t          evt;
    tgt_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PW-1:0]     ptr;
    logic              rw_bit;
    logic              first_wr;
    logic              more_rd;
    logic [BYTE_W-1:0] rd_data;
    logic              byte_end;
    logic              mem_we;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .evt(evt)
    );

    assign byte_end = evt.scl_fall && (bit_cnt == BYTE_END);
    assign mem_we   = (state == ST_WR) && byte_end && !first_wr;

    i2c_byte_store #(.DEPTH(MEM_DEPTH), .WIDTH(BYTE_W)) u_store (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(ptr), .wdata(shreg),
        .raddr(ptr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rw_bit   <= 1'b0;
            first_wr <= 1'b0;
            more_rd  <= 1'b0;
            sda_pull <= 1'b0;
        end else if (evt.stop) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (evt.start) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (evt.scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        if (addr_hit(shreg, OWN_ADDR)) begin
                            sda_pull <= 1'b1;
                            rw_bit   <= shreg[0];
                            first_wr <= 1'b1;
                            state    <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_bit) begin
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[BYTE_W-1];
                            state    <= ST_RD;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (evt.scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        sda_pull <= 1'b1;
                        state    <= ST_WR_ACK;
                        if (first_wr) begin
                            ptr      <= shreg[PW-1:0];
                            first_wr <= 1'b0;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (evt.scl_fall) begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (evt.scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        sda_pull <= 1'b0;
                        ptr      <= ptr + 1'b1;
                        state    <= ST_RD_ACK;
                    end else if (evt.scl_fall) begin
                        shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~shreg[BYTE_W-2];
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise) begin
                        more_rd <= ~evt.sda;
                    end else if (evt.scl_fall) begin
                        if (more_rd) begin
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[BYTE_W-1];
                            bit_cnt  <= '0;
                            state    <= ST_RD;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    pull_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> !evt.scl);

    // R8
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE) && !sda_pull);

    // R3
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_pull);

    // R2
    ack_held_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> sda_pull);

    // R9
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD && byte_end && ptr == PW'(MEM_DEPTH-1)) |=> ptr == '0);
endmodule

// File: tb/i2c_ptr_target_tb.sv
module i2c_ptr_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;
    localparam logic [6:0] OWN = 7'h52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int oe_viol = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] obs_q[$];

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ptr_target #(.OWN_ADDR(OWN)) u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic direct_check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected entries as observed results arrive
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() != 0) begin
                logic [7:0] o;
                exp_t e;
                o = obs_q.pop_front();
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: actual %h expected none", o);
                end else begin
                    e = exp_q.pop_front();
                    if (o !== e.val) begin
                        errors++;
                        $display("FAIL %s: actual %h expected %h", e.tag, o, e.val);
                    end
                end
            end
        end
    end

    // R10: pull enable must not move while SCL is high on both samples
    initial begin
        logic prev_pull;
        logic prev_scl;
        prev_pull = 1'b0;
        prev_scl  = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst && scl_m && prev_scl && (sda_pull != prev_pull)) oe_viol++;
            prev_pull = sda_pull;
            prev_scl  = scl_m;
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        obs_q.push_back({7'd0, a});
    endtask

    task automatic recv_byte(input logic master_ack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(master_ack);
        obs_q.push_back(v);
    endtask

    task automatic settle();
        tick(4);
    endtask

    initial begin
        rst = 1'b1;
        tick(5);
        direct_check({7'd0, sda_pull}, 8'h00, "R1 pull low in reset");
        rst = 1'b0;
        tick(5);
        direct_check({7'd0, sda_pull}, 8'h00, "R1 pull low after reset");

        // write pointer 0x10, data A5 3C
        expect_val(8'h00, "R2 address ack (write)");
        expect_val(8'h00, "R4 pointer byte ack");
        expect_val(8'h00, "R5 data ack A5");
        expect_val(8'h00, "R5 data ack 3C");
        bus_start();
        send_byte({OWN, 1'b0});
        send_byte(8'h10);
        send_byte(8'hA5);
        send_byte(8'h3C);
        bus_stop();
        settle();
        direct_check({7'd0, sda_pull}, 8'h00, "R8 released after stop");

        // combined read from 0x10
        expect_val(8'h00, "R2 address ack");
        expect_val(8'h00, "R4 pointer ack");
        expect_val(8'h00, "R6 read address ack");
        expect_val(8'hA5, "R6 first read byte");
        expect_val(8'h3C, "R7 second read byte");
        expect_val(8'h00, "R1 cleared memory byte");
        bus_start();
        send_byte({OWN, 1'b0});
        send_byte(8'h10);
        bus_start();
        send_byte({OWN, 1'b1});
        recv_byte(1'b0);
        recv_byte(1'b0);
        recv_byte(1'b1);
        settle();
        direct_check({7'd0, sda_pull}, 8'h00, "R7 released after nack");
        // R7: repeated start after nack reads from incremented pointer (0x13)
        expect_val(8'h00, "R7 read address after nack");
        expect_val(8'h00, "R7 byte at 0x13");
        bus_start();
        send_byte({OWN, 1'b1});
        recv_byte(1'b1);
        bus_stop();
        settle();

        // foreign address: no ack, no writes
        expect_val(8'h01, "R3 foreign address nack");
        expect_val(8'h01, "R3 ignored byte 1");
        expect_val(8'h01, "R3 ignored byte 2");
        bus_start();
        send_byte({7'h33, 1'b0});
        send_byte(8'h10);
        send_byte(8'hFF);
        bus_stop();
        settle();
        expect_val(8'h00, "R3 addr ack");
        expect_val(8'h00, "R3 ptr ack");
        expect_val(8'h00, "R3 read addr ack");
        expect_val(8'hA5, "R3 memory unchanged at 0x10");
        bus_start();
        send_byte({OWN, 1'b0});
        send_byte(8'h10);
        bus_start();
        send_byte({OWN, 1'b1});
        recv_byte(1'b1);
        bus_stop();
        settle();

        // stop in the middle of a byte
        expect_val(8'h00, "R8 addr ack");
        expect_val(8'h00, "R8 ptr ack");
        expect_val(8'h00, "R8 data ack");
        bus_start();
        send_byte({OWN, 1'b0});
        send_byte(8'h20);
        send_byte(8'h77);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        settle();
        direct_check({7'd0, sda_pull}, 8'h00, "R8 released after mid-byte stop");
        expect_val(8'h00, "R8 addr ack 2");
        expect_val(8'h00, "R8 ptr ack 2");
        expect_val(8'h00, "R8 read addr ack");
        expect_val(8'h77, "R8 full byte kept");
        expect_val(8'h00, "R8 partial byte discarded");
        bus_start();
        send_byte({OWN, 1'b0});
        send_byte(8'h20);
        bus_start();
        send_byte({OWN, 1'b1});
        recv_byte(1'b0);
        recv_byte(1'b1);
        bus_stop();
        settle();

        // wrap: pointer byte FF -> 0x7F (bit 7 ignored)
        expect_val(8'h00, "R9 addr ack");
        expect_val(8'h00, "R4 ptr ack bit7 set");
        expect_val(8'h00, "R9 data ack at 0x7F");
        expect_val(8'h00, "R9 data ack at 0x00");
        bus_start();
        send_byte({OWN, 1'b0});
        send_byte(8'hFF);
        send_byte(8'h11);
        send_byte(8'h22);
        bus_stop();
        settle();
        expect_val(8'h00, "R9 addr ack r");
        expect_val(8'h00, "R9 ptr ack r");
        expect_val(8'h00, "R9 read addr ack");
        expect_val(8'h11, "R4 byte at 0x7F");
        expect_val(8'h22, "R9 wrapped byte at 0x00");
        expect_val(8'h00, "R9 byte at 0x01");
        bus_start();
        send_byte({OWN, 1'b0});
        send_byte(8'h7F);
        bus_start();
        send_byte({OWN, 1'b1});
        recv_byte(1'b0);
        recv_byte(1'b0);
        recv_byte(1'b1);
        bus_stop();
        settle();

        tick(20);
        direct_check(8'(exp_q.size()), 8'd0, "scoreboard drained");
        direct_check(8'(oe_viol), 8'd0, "R10 pull moved while SCL high");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule